// File: doc/BRIEF.md
# Pad and Peripheral Select Matrix

This block is a configurable crossbar between multiplexed IO pads and the signals of on-chip peripherals. Each peripheral input has an input-select register that chooses a pad input or a fixed level. Each pad has an output-select register that chooses a peripheral output and its output enable, a fixed level, or high impedance. All routing is combinational from the registered selects, so the signal path adds no clock latency.

Configuration goes through a single write-only port. The two upper address bits pick one of four regions: input selects (0), output selects (1), input-select locks (2) and output-select locks (3). The lower bits pick the register index. Every select register has a lock, and the lock is a two-state machine. It starts in `LK_OPEN` after reset. The *seal* transition takes it to `LK_SEALED` when its lock address is written with data bit 0 set. There is no transition out of `LK_SEALED` except *reset*, which returns the lock to `LK_OPEN`. In `LK_OPEN` the select accepts writes. In `LK_SEALED` it holds its value.

After reset every peripheral input reads 0 and every pad is released (output enable low). Software then programs the routes and may seal them.

Top module: `pmx_matrix`

## Requirements
- R1: Input select code 0 drives the peripheral input to 0, and code 1 drives it to 1, whatever the pad inputs are.
- R2: Input select code 2+k routes pad input k to the peripheral input, for every k below the pad count.
- R3: Output select code 0 drives the pad output to 0 with output enable 1. Code 1 drives the pad output to 1 with output enable 1.
- R4: Output select code 2 releases the pad: the output enable is 0 and the pad output is 0.
- R5: Output select code 3+k drives the pad output from peripheral output k and the pad output enable from peripheral output enable k.
- R6: An input select code above 1+pad count drives the peripheral input to 0. An output select code above 2+peripheral output count releases the pad, as code 2 does.
- R7: After reset every input select holds 0 and every output select holds 2. All peripheral inputs are therefore 0, and all pad output enables and pad outputs are 0.
- R8: A write to an open select register takes effect at the clock edge of the write. The new route is visible at the outputs in the same cycle that follows that edge.
- R9: A write with data bit 0 set to a lock address (region 2 or 3, same index) seals that one select register. Later writes to that register are ignored until reset. Other registers stay writable.
- R10: A write with data bit 0 clear to a lock address leaves the lock open.
- R11: Writes are ignored when the write strobe is low, or when the index is not below the register count of the addressed region.
- R12: Reset reopens every sealed lock and restores the default selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W+2 | Region in the top two bits, register index below |
| cfg_wdata | input | DATA_W | Select code, or seal request in bit 0 |
| pad_in | input | N_PAD | Inputs from the pads |
| periph_out | input | N_POUT | Peripheral output data |
| periph_oe | input | N_POUT | Peripheral output enables |
| periph_in | output | N_PIN | Inputs delivered to peripherals |
| pad_out | output | N_PAD | Data driven to the pads |
| pad_oe | output | N_PAD | Output enables to the pads |

## Verification
The bench builds the block with 5 pads, 3 peripheral inputs and 4 peripheral outputs. With these counts both select fields are 3 bits wide and the code 7 is illegal on both sides, so the out-of-range fallback can be reached on inputs and outputs alike. The pad count is not a power of two, so index 5 to 7 writes to the output region are decodable yet invalid. A walked vector table covers every code class. Directed steps then cover lock sealing, the non-sealing lock write and reset reopening.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    // Two-state lock machine per select register
    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    // Configuration address regions (top two address bits)
    typedef enum logic [1:0] {
        RG_IN_SEL   = 2'd0,
        RG_OUT_SEL  = 2'd1,
        RG_IN_LOCK  = 2'd2,
        RG_OUT_LOCK = 2'd3
    } region_e;

    // Reserved select codes
    localparam int IN_CODE_ZERO   = 0;
    localparam int IN_CODE_ONE    = 1;
    localparam int IN_PAD_BASE    = 2;
    localparam int OUT_CODE_ZERO  = 0;
    localparam int OUT_CODE_ONE   = 1;
    localparam int OUT_CODE_HIZ   = 2;
    localparam int OUT_PERIPH_BASE = 3;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int choices);
        return (choices <= 2) ? 1 : $clog2(choices);
    endfunction

endpackage

// File: rtl/pmx_sel_reg.sv
module pmx_sel_reg
    import pmx_pkg::*;
#(
    parameter int             SEL_W     = 3,
    parameter logic [SEL_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic             seal_req,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_o,
    output logic             sealed_o
);

    lock_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // Next state: seal is the only transition, reset the only way back
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (seal_req) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    // Select storage, writable only while open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          sel_q <= RESET_VAL;
        else if (sel_we && state_q == LK_OPEN) sel_q <= wdata;
    end

    // Outputs
    always_comb begin
        sel_o    = sel_q;
        sealed_o = (state_q == LK_SEALED);
    end

    // R9: a sealed register never changes and never reopens
    p_sealed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> $stable(sel_q));
    p_seal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_o |=> sealed_o);
    // R8: an open write lands on the next edge
    p_open_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && !sealed_o) |=> (sel_q == $past(wdata)));
    // R10: no seal request, no seal
    p_no_spurious_seal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sealed_o && !seal_req) |=> !sealed_o);

endmodule

// File: rtl/pmx_cfg_decode.sv
module pmx_cfg_decode
    import pmx_pkg::*;
#(
    parameter int N_PIN  = 6,
    parameter int N_PAD  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = IDX_W + 2
) (
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              seal_bit,
    output logic [N_PIN-1:0]  in_sel_we,
    output logic [N_PIN-1:0]  in_seal,
    output logic [N_PAD-1:0]  out_sel_we,
    output logic [N_PAD-1:0]  out_seal
);

    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             hit_in_sel, hit_out_sel, hit_in_lock, hit_out_lock;

    always_comb begin
        region = region_e'(cfg_addr[ADDR_W-1 -: 2]);
        idx    = cfg_addr[IDX_W-1:0];
    end

    always_comb begin
        hit_in_sel   = 1'b0;
        hit_out_sel  = 1'b0;
        hit_in_lock  = 1'b0;
        hit_out_lock = 1'b0;
        unique case (region)
            RG_IN_SEL:   hit_in_sel   = cfg_we;
            RG_OUT_SEL:  hit_out_sel  = cfg_we;
            RG_IN_LOCK:  hit_in_lock  = cfg_we & seal_bit;
            RG_OUT_LOCK: hit_out_lock = cfg_we & seal_bit;
        endcase
    end

    // Index match per register; out-of-range indices match nothing
    always_comb begin
        for (int k = 0; k < N_PIN; k++) begin
            in_sel_we[k] = hit_in_sel  && (int'(idx) == k);
            in_seal[k]   = hit_in_lock && (int'(idx) == k);
        end
        for (int k = 0; k < N_PAD; k++) begin
            out_sel_we[k] = hit_out_sel  && (int'(idx) == k);
            out_seal[k]   = hit_out_lock && (int'(idx) == k);
        end
    end

endmodule

// File: rtl/pmx_in_route.sv
module pmx_in_route
    import pmx_pkg::*;
#(
    parameter int N_PAD = 8,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_PAD-1:0] pad_in,
    output logic             data_o
);

    always_comb begin
        data_o = 1'b0;
        if (int'(sel_i) == IN_CODE_ONE) data_o = 1'b1;
        for (int k = 0; k < N_PAD; k++) begin
            if (int'(sel_i) == IN_PAD_BASE + k) data_o = pad_in[k];
        end
    end

endmodule

// File: rtl/pmx_out_route.sv
module pmx_out_route
    import pmx_pkg::*;
#(
    parameter int N_POUT = 5,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [N_POUT-1:0] periph_out,
    input  logic [N_POUT-1:0] periph_oe,
    output logic              data_o,
    output logic              oe_o
);

    always_comb begin
        data_o = 1'b0;
        oe_o   = 1'b0;
        if (int'(sel_i) == OUT_CODE_ZERO) begin
            oe_o = 1'b1;
        end else if (int'(sel_i) == OUT_CODE_ONE) begin
            data_o = 1'b1;
            oe_o   = 1'b1;
        end
        for (int k = 0; k < N_POUT; k++) begin
            if (int'(sel_i) == OUT_PERIPH_BASE + k) begin
                data_o = periph_out[k];
                oe_o   = periph_oe[k];
            end
        end
    end

endmodule

// File: rtl/pmx_matrix.sv
module pmx_matrix
    import pmx_pkg::*;
#(
    parameter int N_PAD     = 8,
    parameter int N_PIN     = 6,
    parameter int N_POUT    = 5,
    parameter int IN_SEL_W  = width_for(N_PAD + IN_PAD_BASE),
    parameter int OUT_SEL_W = width_for(N_POUT + OUT_PERIPH_BASE),
    parameter int DATA_W    = max_int(IN_SEL_W, OUT_SEL_W),
    parameter int IDX_W     = width_for(max_int(N_PAD, N_PIN)),
    parameter int ADDR_W    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_PAD-1:0]  pad_in,
    input  logic [N_POUT-1:0] periph_out,
    input  logic [N_POUT-1:0] periph_oe,
    output logic [N_PIN-1:0]  periph_in,
    output logic [N_PAD-1:0]  pad_out,
    output logic [N_PAD-1:0]  pad_oe
);

    localparam logic [IN_SEL_W-1:0]  IN_RESET  = IN_SEL_W'(IN_CODE_ZERO);
    localparam logic [OUT_SEL_W-1:0] OUT_RESET = OUT_SEL_W'(OUT_CODE_HIZ);

    logic [N_PIN-1:0] in_sel_we, in_seal, in_sealed;
    logic [N_PAD-1:0] out_sel_we, out_seal, out_sealed;
    logic [IN_SEL_W-1:0]  in_sel  [N_PIN];
    logic [OUT_SEL_W-1:0] out_sel [N_PAD];

    pmx_cfg_decode #(
        .N_PIN (N_PIN),
        .N_PAD (N_PAD),
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .seal_bit  (cfg_wdata[0]),
        .in_sel_we (in_sel_we),
        .in_seal   (in_seal),
        .out_sel_we(out_sel_we),
        .out_seal  (out_seal)
    );

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        pmx_sel_reg #(
            .SEL_W    (IN_SEL_W),
            .RESET_VAL(IN_RESET)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_we  (in_sel_we[i]),
            .seal_req(in_seal[i]),
            .wdata   (cfg_wdata[IN_SEL_W-1:0]),
            .sel_o   (in_sel[i]),
            .sealed_o(in_sealed[i])
        );

        pmx_in_route #(
            .N_PAD(N_PAD),
            .SEL_W(IN_SEL_W)
        ) u_route (
            .sel_i (in_sel[i]),
            .pad_in(pad_in),
            .data_o(periph_in[i])
        );

        // R1: the constant-one code yields 1
        p_in_const_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(in_sel[i]) == IN_CODE_ONE) |-> periph_in[i]);
        // R6: illegal input code reads as 0
        p_in_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(in_sel[i]) >= N_PAD + IN_PAD_BASE) |-> !periph_in[i]);
    end

    for (genvar j = 0; j < N_PAD; j++) begin : g_pad
        pmx_sel_reg #(
            .SEL_W    (OUT_SEL_W),
            .RESET_VAL(OUT_RESET)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_we  (out_sel_we[j]),
            .seal_req(out_seal[j]),
            .wdata   (cfg_wdata[OUT_SEL_W-1:0]),
            .sel_o   (out_sel[j]),
            .sealed_o(out_sealed[j])
        );

        pmx_out_route #(
            .N_POUT(N_POUT),
            .SEL_W (OUT_SEL_W)
        ) u_route (
            .sel_i     (out_sel[j]),
            .periph_out(periph_out),
            .periph_oe (periph_oe),
            .data_o    (pad_out[j]),
            .oe_o      (pad_oe[j])
        );

        // R4: the high-impedance code releases the pad
        p_out_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(out_sel[j]) == OUT_CODE_HIZ) |-> (!pad_oe[j] && !pad_out[j]));
        // R3: constant codes always enable the pad
        p_out_const_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(out_sel[j]) <= OUT_CODE_ONE) |-> pad_oe[j]);
    end

    // R7: first cycle out of reset sees the default routes
    p_reset_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (periph_in == '0 && pad_oe == '0 && pad_out == '0));

    // R12: reset leaves every lock open
    p_reset_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_sealed == '0 && out_sealed == '0));

endmodule

// File: tb/pmx_matrix_tb.sv
module pmx_matrix_tb;

    localparam int NP  = 5;
    localparam int NI  = 3;
    localparam int NO  = 4;

    typedef struct packed {
        logic [3:0] tag;
        logic       we;
        logic [1:0] rg;
        logic [2:0] idx;
        logic [2:0] dat;
        logic [4:0] pad;
        logic [3:0] pout;
        logic [3:0] poe;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b1, 2'd0, 3'd0, 3'd1, 5'b00000, 4'h0, 4'h0},
        '{4'd1,  1'b1, 2'd0, 3'd1, 3'd0, 5'b11111, 4'h0, 4'h0},
        '{4'd2,  1'b1, 2'd0, 3'd0, 3'd2, 5'b00001, 4'h0, 4'h0},
        '{4'd2,  1'b1, 2'd0, 3'd1, 3'd6, 5'b10000, 4'h0, 4'h0},
        '{4'd2,  1'b1, 2'd0, 3'd2, 3'd4, 5'b00100, 4'h0, 4'h0},
        '{4'd6,  1'b1, 2'd0, 3'd2, 3'd7, 5'b11111, 4'h0, 4'h0},
        '{4'd3,  1'b1, 2'd1, 3'd0, 3'd0, 5'b01010, 4'hF, 4'hF},
        '{4'd3,  1'b1, 2'd1, 3'd1, 3'd1, 5'b01010, 4'h0, 4'h0},
        '{4'd5,  1'b1, 2'd1, 3'd2, 3'd3, 5'b00000, 4'h1, 4'h1},
        '{4'd5,  1'b1, 2'd1, 3'd3, 3'd6, 5'b00000, 4'h8, 4'h0},
        '{4'd5,  1'b1, 2'd1, 3'd4, 3'd5, 5'b00000, 4'h4, 4'h4},
        '{4'd6,  1'b1, 2'd1, 3'd4, 3'd7, 5'b00000, 4'hF, 4'hF},
        '{4'd4,  1'b1, 2'd1, 3'd0, 3'd2, 5'b00000, 4'hF, 4'hF},
        '{4'd11, 1'b1, 2'd0, 3'd5, 3'd1, 5'b11111, 4'hA, 4'h5},
        '{4'd11, 1'b1, 2'd1, 3'd6, 3'd1, 5'b11111, 4'hA, 4'h5},
        '{4'd11, 1'b0, 2'd0, 3'd0, 3'd1, 5'b00000, 4'hA, 4'h5},
        '{4'd10, 1'b1, 2'd2, 3'd0, 3'd0, 5'b00000, 4'h0, 4'h0},
        '{4'd8,  1'b1, 2'd0, 3'd0, 3'd1, 5'b00000, 4'h0, 4'h0},
        '{4'd9,  1'b1, 2'd2, 3'd0, 3'd1, 5'b00000, 4'h0, 4'h0},
        '{4'd9,  1'b1, 2'd0, 3'd0, 3'd0, 5'b00000, 4'h0, 4'h0},
        '{4'd9,  1'b1, 2'd0, 3'd1, 3'd1, 5'b00000, 4'h0, 4'h0},
        '{4'd9,  1'b1, 2'd3, 3'd1, 3'd1, 5'b00000, 4'h0, 4'h0},
        '{4'd9,  1'b1, 2'd1, 3'd1, 3'd2, 5'b00000, 4'h0, 4'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [2:0]    cfg_wdata = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NO-1:0] periph_out = '0;
    logic [NO-1:0] periph_oe = '0;
    logic [NI-1:0] periph_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    int  m_in  [NI];
    int  m_out [NP];
    bit  lk_in [NI];
    bit  lk_out[NP];

    always #5 clk = ~clk;

    pmx_matrix #(.N_PAD(NP), .N_PIN(NI), .N_POUT(NO)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pad_in    (pad_in),
        .periph_out(periph_out),
        .periph_oe (periph_oe),
        .periph_in (periph_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    // Expected values from the requirement text
    function automatic logic [NI-1:0] exp_pin();
        logic [NI-1:0] r;
        for (int i = 0; i < NI; i++) begin
            int s = m_in[i];
            if (s == 1)                  r[i] = 1'b1;
            else if (s >= 2 && s < 2+NP) r[i] = pad_in[s-2];
            else                         r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic exp_pad(output logic [NP-1:0] d, output logic [NP-1:0] e);
        for (int j = 0; j < NP; j++) begin
            int s = m_out[j];
            if (s == 0)                  begin d[j] = 1'b0; e[j] = 1'b1; end
            else if (s == 1)             begin d[j] = 1'b1; e[j] = 1'b1; end
            else if (s >= 3 && s < 3+NO) begin d[j] = periph_out[s-3]; e[j] = periph_oe[s-3]; end
            else                         begin d[j] = 1'b0; e[j] = 1'b0; end
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NI; i++) begin m_in[i] = 0; lk_in[i] = 1'b0; end
        for (int j = 0; j < NP; j++) begin m_out[j] = 2; lk_out[j] = 1'b0; end
    endtask

    task automatic model_write(input int rg, input int idx, input int dat);
        case (rg)
            0: if (idx < NI && !lk_in[idx])  m_in[idx]  = dat;
            1: if (idx < NP && !lk_out[idx]) m_out[idx] = dat;
            2: if (idx < NI && dat[0])       lk_in[idx]  = 1'b1;
            default: if (idx < NP && dat[0]) lk_out[idx] = 1'b1;
        endcase
    endtask

    task automatic check_all(input string req);
        logic [NI-1:0] ei;
        logic [NP-1:0] ed, ee;
        ei = exp_pin();
        exp_pad(ed, ee);
        n_checks++;
        if (periph_in !== ei || pad_out !== ed || pad_oe !== ee) begin
            n_fails++;
            $display("FAIL %s: actual in=%b out=%b oe=%b expected in=%b out=%b oe=%b",
                     req, periph_in, pad_out, pad_oe, ei, ed, ee);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_we = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_step(input bit we, input int rg, input int idx, input int dat, input string req);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = {2'(rg), 3'(idx)};
        cfg_wdata = 3'(dat);
        if (we) model_write(rg, idx, dat);
        @(negedge clk);
        cfg_we = 1'b0;
        check_all(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R8: watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        pad_in = '1; periph_out = '1; periph_oe = '1;
        do_reset();

        // R7: defaults after reset, with all inputs high
        n_checks++;
        if (periph_in !== '0 || pad_oe !== '0 || pad_out !== '0) begin
            n_fails++;
            $display("FAIL R7: actual in=%b out=%b oe=%b expected all zero", periph_in, pad_out, pad_oe);
        end
        check_all("R7");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            pad_in     = VEC[v].pad;
            periph_out = VEC[v].pout;
            periph_oe  = VEC[v].poe;
            cfg_step(VEC[v].we, int'(VEC[v].rg), int'(VEC[v].idx), int'(VEC[v].dat),
                     tag_name(int'(VEC[v].tag)));
        end

        // R2: pad input changes propagate with no clock
        @(negedge clk);
        cfg_step(1'b1, 0, 2, 5, "R2");
        pad_in = 5'b01000;
        #1 check_all("R2");
        pad_in = 5'b10111;
        #1 check_all("R2");

        // R5: peripheral enable toggles pass straight to the pad
        cfg_step(1'b1, 1, 3, 4, "R5");
        periph_out = 4'b0010; periph_oe = 4'b0000;
        #1 check_all("R5");
        periph_oe = 4'b0010;
        #1 check_all("R5");

        // R12: reset reopens sealed registers and restores defaults
        pad_in = '1; periph_out = '1; periph_oe = '1;
        do_reset();
        check_all("R12");
        cfg_step(1'b1, 0, 0, 3, "R12");
        n_checks++;
        if (periph_in[0] !== 1'b1) begin
            n_fails++;
            $display("FAIL R12: actual periph_in[0]=%b expected 1 after reopen", periph_in[0]);
        end
        cfg_step(1'b1, 1, 1, 1, "R12");

        // R9: seal in-select 2, verify a following write is ignored
        cfg_step(1'b1, 0, 2, 1, "R8");
        cfg_step(1'b1, 2, 2, 1, "R9");
        cfg_step(1'b1, 0, 2, 0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule